// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight edge-triggered request lines, ranks them by fixed priority and raises one interrupt line towards a processor. When the processor acknowledges, the block answers one cycle later with an 8-bit vector. The vector is formed from a programmable base and the number of the winning input. If the winning input carries a subordinate controller, the block names that input instead, so that the subordinate can supply the vector.

Software talks to the block through a byte-wide port with two addresses: a command address and a data address. A byte with bit 4 set, written to the command address, starts a short sequence of setup words on the data address. That sequence fixes the vector base, the cascade arrangement and the end-of-interrupt style. Once setup is complete, data writes load the mask. Command bytes then retire in-service entries or choose which status register a command-address read returns. A pin selects whether the part acts as the primary or as a subordinate in a cascade.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the block waits for a setup start byte. Data-address writes are ignored, `irq_out` stays low and acknowledges produce no output until setup completes.
- R2: A command byte with bit 4 set restarts setup. Its bit 1 set means single (no cascade), which skips the cascade word. Its bit 0 set means a mode word follows. When setup ends, the mask is all zeros and command-address reads return the request register.
- R3: The vector word's bits 7:3 are the base. An acknowledge of input n yields `ack_vector` = base[7:3] concatenated with n, with `ack_valid` high for one cycle in the cycle after the acknowledge.
- R4: In normal operation a data-address write loads the mask (1 = input disabled), and a data-address read returns it. A masked request still shows in the request register but never raises `irq_out`.
- R5: A request bit is set on a rising edge of its line and is dropped as soon as the line is low. A line held high after its acknowledge does not request again until it falls and rises.
- R6: Input 0 has the highest priority. `irq_out` is high only while some unmasked pending input has higher priority than every in-service bit.
- R7: Without automatic end-of-interrupt, an acknowledge clears the winner's request bit and sets its in-service bit.
- R8: Command byte 0x60+n clears in-service bit n only. Command byte 0x20 clears the highest-priority in-service bit.
- R9: Command byte 0x0B selects the in-service register for command-address reads, and 0x0A selects the request register. The choice persists across other writes.
- R10: Mode word bit 1 selects automatic end-of-interrupt. In that mode an acknowledge leaves the in-service register at zero.
- R11: An acknowledge with no eligible request returns base+7 and changes neither the in-service nor the request register. This holds even when input 7 is masked.
- R12: On a cascaded primary, the cascade word is a mask of inputs that carry subordinates. Acknowledging such an input sets its in-service bit and pulses `cas_valid` with `cas_index` = n instead of `ack_valid`.
- R13: On a cascaded subordinate (`role_sub` high), the cascade word's bits 2:0 are its identity. An acknowledge takes effect only when `cas_id_in` equals that identity; otherwise no output pulses and no register changes.
- R14: Restarting setup during operation clears the in-service register and the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| irq_in | input | 8 | Request lines, rising-edge sensitive |
| role_sub | input | 1 | High = subordinate in a cascade |
| cas_id_in | input | 3 | Identity broadcast by the primary during an acknowledge |
| int_ack | input | 1 | Acknowledge strobe, one cycle |
| irq_out | output | 1 | Interrupt to the processor |
| ack_valid | output | 1 | Vector valid pulse |
| ack_vector | output | 8 | Vector delivered for the acknowledge |
| cas_valid | output | 1 | Acknowledge served by a subordinate |
| cas_index | output | 3 | Input that carries the serving subordinate |

## Verification
Most internal faults become visible at the ports within a cycle or two. A stale in-service bit shows at once as `irq_out` staying low for a request that should win. A lost or extra request bit shows as a wrong vector on the next acknowledge, or as a wrong request readback. A wrong setup state shows when a later data write lands in the mask instead of a setup register, or when a vector base comes out wrong. The stimulus therefore follows every acknowledge and every end-of-interrupt with a readback or an `irq_out` check, so that a corrupted register is found before the next stimulus can hide it.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NIN = 8;
    localparam int IW  = $clog2(NIN);
    localparam int DW  = 8;

    typedef enum logic [2:0] {
        ST_WAIT_W1,
        ST_WAIT_W2,
        ST_WAIT_W3,
        ST_WAIT_W4,
        ST_RUN
    } init_st_t;

    typedef struct packed {
        logic [DW-1:0] base;
        logic [DW-1:0] casc_word;
        logic          single;
        logic          auto_eoi;
        logic          running;
    } pic_cfg_t;

    typedef struct packed {
        logic          restart;
        logic          spec;
        logic          nonspec;
        logic [IW-1:0] idx;
    } pic_cmd_t;

    // Returns {found, index} of the lowest-numbered set bit.
    function automatic logic [IW:0] first_set(input logic [NIN-1:0] v);
        logic [IW:0] r;
        r = '0;
        for (int i = NIN - 1; i >= 0; i--) begin
            if (v[i]) r = {1'b1, IW'(i)};
        end
        return r;
    endfunction

    function automatic logic [NIN-1:0] onehot(input logic [IW-1:0] i);
        return NIN'(1) << i;
    endfunction
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
    import pic_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output pic_cfg_t      cfg,
    output logic [NIN-1:0] imr,
    output logic          rd_isr,
    output pic_cmd_t      cmd
);
    init_st_t      st;
    logic [DW-1:0] base_q;
    logic [DW-1:0] casc_q;
    logic          single_q;
    logic          need_w4_q;
    logic          aeoi_q;
    logic          start_w;
    logic          run;

    assign start_w = wr && !addr && wdata[4];
    assign run     = (st == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_WAIT_W1;
            base_q    <= '0;
            casc_q    <= '0;
            single_q  <= 1'b0;
            need_w4_q <= 1'b0;
            aeoi_q    <= 1'b0;
            imr       <= '0;
            rd_isr    <= 1'b0;
        end else if (start_w) begin
            st        <= ST_WAIT_W2;
            single_q  <= wdata[1];
            need_w4_q <= wdata[0];
            aeoi_q    <= 1'b0;
            imr       <= '0;
            rd_isr    <= 1'b0;
        end else if (wr && addr) begin
            unique case (st)
                ST_WAIT_W2: begin
                    base_q <= wdata;
                    if (!single_q)      st <= ST_WAIT_W3;
                    else if (need_w4_q) st <= ST_WAIT_W4;
                    else                st <= ST_RUN;
                end
                ST_WAIT_W3: begin
                    casc_q <= wdata;
                    st     <= need_w4_q ? ST_WAIT_W4 : ST_RUN;
                end
                ST_WAIT_W4: begin
                    aeoi_q <= wdata[1];
                    st     <= ST_RUN;
                end
                ST_RUN:  imr <= wdata;
                default: ;
            endcase
        end else if (wr && !addr && run && wdata[3] && wdata[1]) begin
            rd_isr <= wdata[0];
        end
    end

    always_comb begin
        cfg.base      = base_q;
        cfg.casc_word = casc_q;
        cfg.single    = single_q;
        cfg.auto_eoi  = aeoi_q;
        cfg.running   = run;
        cmd.restart   = start_w;
        cmd.spec      = wr && !addr && run && !wdata[4] && !wdata[3]
                        && (wdata[7:5] == 3'b011);
        cmd.nonspec   = wr && !addr && run && !wdata[4] && !wdata[3]
                        && (wdata[7:5] == 3'b001);
        cmd.idx       = wdata[IW-1:0];
    end

    a_r2_restart_clears: assert property (@(posedge clk) disable iff (rst)
        start_w |=> (st == ST_WAIT_W2) && (imr == '0) && !rd_isr);

    a_r4_mask_load: assert property (@(posedge clk) disable iff (rst)
        (wr && addr && run) |=> (imr == $past(wdata)));

    a_r1_no_data_before_start: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_WAIT_W1) && !start_w) |=> (st == ST_WAIT_W1));
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve
    import pic_pkg::*;
(
    input  logic [NIN-1:0] pend,
    input  logic [NIN-1:0] isr,
    output logic           found,
    output logic [IW-1:0]  win_idx
);
    logic [NIN-1:0] elig;

    for (genvar g = 0; g < NIN; g++) begin : g_elig
        assign elig[g] = pend[g] && (isr[g:0] == '0);
    end

    always_comb begin
        {found, win_idx} = first_set(elig);
    end

    always_comb begin
        if (found) a_r6_win_eligible: assert (elig[win_idx]);
    end
endmodule

// File: rtl/pic_req_core.sv
module pic_req_core
    import pic_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NIN-1:0] irq_in,
    input  pic_cfg_t       cfg,
    input  pic_cmd_t       cmd,
    input  logic           ack,
    input  logic           role_sub,
    input  logic [IW-1:0]  cas_id_in,
    input  logic           found,
    input  logic [IW-1:0]  win_idx,
    output logic [NIN-1:0] irr,
    output logic [NIN-1:0] isr,
    output logic           ack_valid,
    output logic [DW-1:0]  ack_vec,
    output logic           cas_valid,
    output logic [IW-1:0]  cas_idx
);
    logic [NIN-1:0] line_q;
    logic [NIN-1:0] rise;
    logic [NIN-1:0] win_mask;
    logic [NIN-1:0] eoi_mask;
    logic [IW:0]    top_isr;
    logic           sub_mode;
    logic           id_ok;
    logic           take;
    logic           cas_hit;

    assign sub_mode = role_sub && !cfg.single;
    assign id_ok    = !sub_mode || (cas_id_in == cfg.casc_word[IW-1:0]);
    assign take     = ack && cfg.running && id_ok;
    assign rise     = irq_in & ~line_q;
    assign win_mask = found ? onehot(win_idx) : '0;
    assign cas_hit  = take && found && !role_sub && !cfg.single
                      && cfg.casc_word[win_idx];

    always_comb begin
        top_isr  = first_set(isr);
        eoi_mask = '0;
        if (cmd.spec)                     eoi_mask = onehot(cmd.idx);
        else if (cmd.nonspec && top_isr[IW]) eoi_mask = onehot(top_isr[IW-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q    <= '0;
            irr       <= '0;
            isr       <= '0;
            ack_valid <= 1'b0;
            ack_vec   <= '0;
            cas_valid <= 1'b0;
            cas_idx   <= '0;
        end else begin
            line_q <= irq_in;
            irr    <= (irr | rise) & irq_in & ~(take ? win_mask : '0);
            if (cmd.restart)
                isr <= '0;
            else
                isr <= (isr & ~eoi_mask)
                       | ((take && !cfg.auto_eoi) ? win_mask : '0);
            ack_valid <= take && !cas_hit;
            cas_valid <= cas_hit;
            cas_idx   <= win_idx;
            if (take)
                ack_vec <= {cfg.base[DW-1:IW], found ? win_idx : {IW{1'b1}}};
        end
    end

    a_r3_pulse_follows_ack: assert property (@(posedge clk) disable iff (rst)
        (ack_valid || cas_valid) |-> $past(ack));

    a_r12_one_responder: assert property (@(posedge clk) disable iff (rst)
        !(ack_valid && cas_valid));

    a_r10_aeoi_no_service: assert property (@(posedge clk) disable iff (rst)
        (cfg.running && cfg.auto_eoi) |-> (isr == '0));

    a_r8_spec_eoi_clears: assert property (@(posedge clk) disable iff (rst)
        (cmd.spec && !take) |=> !isr[$past(cmd.idx)]);

    a_r5_irr_tracks_line: assert property (@(posedge clk) disable iff (rst)
        (irr & ~$past(irq_in)) == '0);

    a_r13_foreign_id_idle: assert property (@(posedge clk) disable iff (rst)
        (ack && !id_ok) |=> !ack_valid && !cas_valid && $stable(isr));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_addr,
    input  logic          bus_wr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic [7:0]    irq_in,
    input  logic          role_sub,
    input  logic [2:0]    cas_id_in,
    input  logic          int_ack,
    output logic          irq_out,
    output logic          ack_valid,
    output logic [7:0]    ack_vector,
    output logic          cas_valid,
    output logic [2:0]    cas_index
);
    pic_cfg_t       cfg;
    pic_cmd_t       cmd;
    logic [NIN-1:0] imr;
    logic [NIN-1:0] irr;
    logic [NIN-1:0] isr;
    logic           rd_isr;
    logic           found;
    logic [IW-1:0]  win_idx;

    pic_cfg_regs u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .cfg    (cfg),
        .imr    (imr),
        .rd_isr (rd_isr),
        .cmd    (cmd)
    );

    pic_prio_resolve u_prio (
        .pend    (irr & ~imr),
        .isr     (isr),
        .found   (found),
        .win_idx (win_idx)
    );

    pic_req_core u_core (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .cfg       (cfg),
        .cmd       (cmd),
        .ack       (int_ack),
        .role_sub  (role_sub),
        .cas_id_in (cas_id_in),
        .found     (found),
        .win_idx   (win_idx),
        .irr       (irr),
        .isr       (isr),
        .ack_valid (ack_valid),
        .ack_vec   (ack_vector),
        .cas_valid (cas_valid),
        .cas_idx   (cas_index)
    );

    assign irq_out   = cfg.running && found;
    assign bus_rdata = bus_addr ? imr : (rd_isr ? isr : irr);

    a_r1_quiet_until_setup: assert property (@(posedge clk) disable iff (rst)
        !cfg.running |-> !irq_out);

    a_r4_masked_never_raise: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> ((irr & ~imr) != '0));

    a_r14_restart_clears_isr: assert property (@(posedge clk) disable iff (rst)
        cmd.restart |=> (isr == '0));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int OP_WR = 1, OP_IRQ = 2, OP_RD = 3, OP_ACK = 4, OP_CAS = 5, OP_INT = 6;

    function automatic logic [31:0] mk(input int op, input int rq, input int a,
                                       input int d, input int e);
        return {op[3:0], rq[3:0], 7'd0, a[0], d[7:0], e[7:0]};
    endfunction

    localparam int NV = 50;
    localparam logic [31:0] TBL [NV] = '{
        mk(OP_WR, 2, 0, 8'h11, 0),   // R2 start, cascaded, mode word follows
        mk(OP_WR, 3, 1, 8'h20, 0),   // R3 base 0x20
        mk(OP_WR,12, 1, 8'h04, 0),   // R12 subordinate on input 2
        mk(OP_WR, 2, 1, 8'h01, 0),   // R2 normal EOI
        mk(OP_RD, 9, 0, 0, 8'h00),   // R9 request register by default
        mk(OP_RD, 2, 1, 0, 8'h00),   // R2 mask cleared
        mk(OP_WR, 4, 1, 8'hF0, 0),   // R4 mask inputs 4..7
        mk(OP_RD, 4, 1, 0, 8'hF0),   // R4
        mk(OP_IRQ,5, 0, 8'h08, 0),   // R5 input 3 rises
        mk(OP_INT,6, 0, 0, 1),       // R6
        mk(OP_RD, 5, 0, 0, 8'h08),   // R5
        mk(OP_ACK,3, 0, 0, 8'h23),   // R3 R7
        mk(OP_WR, 9, 0, 8'h0B, 0),   // R9 select in-service
        mk(OP_RD, 7, 0, 0, 8'h08),   // R7
        mk(OP_IRQ,6, 0, 8'h0A, 0),   // R6 input 1 rises above 3
        mk(OP_INT,6, 0, 0, 1),       // R6
        mk(OP_ACK,6, 0, 0, 8'h21),   // R6
        mk(OP_RD, 7, 0, 0, 8'h0A),   // R7
        mk(OP_INT,5, 0, 0, 0),       // R5 held lines do not re-request
        mk(OP_WR, 9, 0, 8'h0A, 0),   // R9
        mk(OP_RD, 5, 0, 0, 8'h00),   // R5
        mk(OP_WR, 9, 0, 8'h0B, 0),   // R9
        mk(OP_WR, 8, 0, 8'h20, 0),   // R8 non-specific
        mk(OP_RD, 8, 0, 0, 8'h08),   // R8
        mk(OP_WR, 8, 0, 8'h63, 0),   // R8 specific 3
        mk(OP_RD, 8, 0, 0, 8'h00),   // R8
        mk(OP_IRQ,5, 0, 8'h00, 0),   // R5
        mk(OP_IRQ,4, 0, 8'h40, 0),   // R4 masked input 6
        mk(OP_INT,4, 0, 0, 0),       // R4
        mk(OP_WR, 9, 0, 8'h0A, 0),   // R9
        mk(OP_RD, 4, 0, 0, 8'h40),   // R4
        mk(OP_ACK,11,0, 0, 8'h27),   // R11 with input 7 masked
        mk(OP_RD, 11,0, 0, 8'h40),   // R11 request register unchanged
        mk(OP_WR, 9, 0, 8'h0B, 0),   // R9
        mk(OP_RD, 11,0, 0, 8'h00),   // R11
        mk(OP_WR, 4, 1, 8'h00, 0),   // R4 unmask
        mk(OP_INT,4, 0, 0, 1),       // R4
        mk(OP_IRQ,12,0, 8'h44, 0),   // R12 input 2 rises
        mk(OP_CAS,12,0, 0, 8'h02),   // R12
        mk(OP_RD, 12,0, 0, 8'h04),   // R12
        mk(OP_INT,6, 0, 0, 0),       // R6 blocked by in-service 2
        mk(OP_WR, 8, 0, 8'h62, 0),   // R8
        mk(OP_INT,6, 0, 0, 1),       // R6
        mk(OP_ACK,7, 0, 0, 8'h26),   // R7
        mk(OP_WR, 8, 0, 8'h66, 0),   // R8
        mk(OP_IRQ,5, 0, 8'h01, 0),   // R5 input 0 rises
        mk(OP_IRQ,11,0, 8'h00, 0),   // R11 and vanishes
        mk(OP_INT,5, 0, 0, 0),       // R5
        mk(OP_ACK,11,0, 0, 8'h27),   // R11 spurious
        mk(OP_RD, 11,0, 0, 8'h00)    // R11
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = '0;
    logic       role_sub = 1'b0;
    logic [2:0] cas_id_in = '0;
    logic       int_ack = 1'b0;
    logic       irq_out;
    logic       ack_valid;
    logic [7:0] ack_vector;
    logic       cas_valid;
    logic [2:0] cas_index;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .role_sub(role_sub), .cas_id_in(cas_id_in), .int_ack(int_ack),
        .irq_out(irq_out), .ack_valid(ack_valid), .ack_vector(ack_vector),
        .cas_valid(cas_valid), .cas_index(cas_index)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input int rq, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %02h expected %02h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic rd(input int rq, input logic a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(rq, bus_rdata, exp);
    endtask

    // Pulses the acknowledge; outputs are registered and read at the next falling edge.
    task automatic pulse_ack();
        @(negedge clk);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state and nothing works before setup
        chk(1, {7'd0, irq_out}, 8'h00);
        set_irq(8'h01);
        wr(1'b1, 8'h55);
        chk(1, {7'd0, irq_out}, 8'h00);
        rd(1, 1'b1, 8'h00);
        pulse_ack();
        chk(1, {6'd0, ack_valid, cas_valid}, 8'h00);
        set_irq(8'h00);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            int         op;
            int         rq;
            logic       a;
            logic [7:0] d;
            logic [7:0] e;
            op = int'(TBL[k][31:28]);
            rq = int'(TBL[k][27:24]);
            a  = TBL[k][16];
            d  = TBL[k][15:8];
            e  = TBL[k][7:0];
            case (op)
                OP_WR:  wr(a, d);
                OP_IRQ: set_irq(d);
                OP_RD:  rd(rq, a, e);
                OP_INT: begin
                    @(negedge clk);
                    chk(rq, {7'd0, irq_out}, e);
                end
                OP_ACK: begin
                    pulse_ack();
                    chk(rq, {7'd0, ack_valid}, 8'h01);
                    chk(rq, ack_vector, e);
                    chk(rq, {7'd0, cas_valid}, 8'h00);
                end
                OP_CAS: begin
                    pulse_ack();
                    chk(rq, {7'd0, cas_valid}, 8'h01);
                    chk(rq, {5'd0, cas_index}, e);
                    chk(rq, {7'd0, ack_valid}, 8'h00);
                end
                default: ;
            endcase
        end

        // R14 restart while an entry is in service
        set_irq(8'h02);
        pulse_ack();
        chk(14, ack_vector, 8'h21);
        wr(1'b1, 8'hAA);
        wr(1'b0, 8'h11); wr(1'b1, 8'h30); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        wr(1'b0, 8'h0B);
        rd(14, 1'b0, 8'h00);
        rd(14, 1'b1, 8'h00);
        set_irq(8'h00);

        // R2 single mode skips the cascade word; R10 automatic end-of-interrupt
        wr(1'b0, 8'h13); wr(1'b1, 8'h48); wr(1'b1, 8'h03);
        set_irq(8'h10);
        pulse_ack();
        chk(10, ack_vector, 8'h4C);
        wr(1'b0, 8'h0B);
        rd(10, 1'b0, 8'h00);
        set_irq(8'h14);
        pulse_ack();
        chk(2, {6'd0, ack_valid, cas_valid}, 8'h02);
        chk(2, ack_vector, 8'h4A);
        set_irq(8'h00);

        // R13 subordinate answers only to its own identity
        role_sub = 1'b1;
        wr(1'b0, 8'h11); wr(1'b1, 8'h28); wr(1'b1, 8'h02); wr(1'b1, 8'h01);
        set_irq(8'h01);
        cas_id_in = 3'd3;
        pulse_ack();
        chk(13, {6'd0, ack_valid, cas_valid}, 8'h00);
        rd(13, 1'b0, 8'h01);
        cas_id_in = 3'd2;
        pulse_ack();
        chk(13, {6'd0, ack_valid, cas_valid}, 8'h02);
        chk(13, ack_vector, 8'h28);
        role_sub = 1'b0;
        set_irq(8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule